// File: doc/BRIEF.md
# Trace Address Comparator Bank with Sticky Match

This block is a bank of address comparators for an instruction-trace unit attached to a processor whose load/store unit keeps transferring data after later instructions have retired. Each comparator is set up as either a single-address comparator (equality after a don't-care bit mask) or an inclusive range comparator. It watches either retired instruction addresses or data-transfer addresses. Every comparator drives four separate registered match outputs, one for each consumer in the trace unit: event logic, trace enable, the start/stop block and data-view filtering.

An instruction-address comparator that matches a load/store instruction sets a sticky bit and records that instruction's transfer tag. The bit stays set until a completion report with the same tag arrives. While it is set, the data-view output stays asserted for every comparator kind. The event output stays asserted only for range comparators, so that a single-address comparator still gives the counters and sequencer one pulse per match. The trace-enable and start/stop outputs never look at the sticky bit.

All inputs are sampled on every clock. The address and completion inputs carry a valid qualifier but no ready signal, because the block accepts every beat and never applies back-pressure. The instruction that follows a traced load/store cannot itself be a load/store or an indirect branch, so at most one outstanding sticky tag per comparator is enough.

Top module: `trc_cmp_bank`

## Requirements
- R1: An enabled instruction-address comparator sets its sticky bit and captures `ia_tag` when `ia_valid` is high, its address matches and `ia_is_data` is 1. A match with `ia_is_data` = 0 leaves the sticky bit clear.
- R2: A set sticky bit clears on the clock edge at which `dc_valid` is high and `dc_tag` equals the captured tag. A completion that carries any other tag has no effect.
- R3: A comparator with `cfg_data` = 1 compares `da_addr` whenever `da_valid` is high and never sets its sticky bit. All four of its outputs follow the raw data-address match only.
- R4: `hit_view` is the raw match OR the sticky bit, for both single and range comparators.
- R5: `hit_event` is the raw match OR the sticky bit for a range comparator (`cfg_range` = 1). For a single comparator (`cfg_range` = 0) it is the raw match only, one cycle per matching beat.
- R6: `hit_tenable` and `hit_startstop` equal the raw match for every comparator kind and ignore the sticky bit.
- R7: A range comparator matches when `cfg_lo` <= address <= `cfg_hi`, unsigned, with both bounds included.
- R8: A single comparator matches when `((address ^ cfg_lo) & ~cfg_mask) == 0`. A mask bit of 1 marks an address bit as don't-care.
- R9: If a comparator matches a new load/store in the same cycle that the completion for its current tag arrives, the sticky bit stays set and takes the new tag.
- R10: A pulse on `cfg_wr[i]`, a low `cfg_en[i]` or a low `unit_en` clears sticky bit i. While `unit_en` or `cfg_en[i]` is low, the outputs of comparator i go to 0.
- R11: All outputs are registered. Outputs at edge t+1 reflect the inputs sampled at edge t and the sticky bit held before edge t. All outputs and sticky bits reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Global enable for the whole bank |
| cfg_en | input | N | Per-comparator enable |
| cfg_range | input | N | 1 = range comparator, 0 = single comparator |
| cfg_data | input | N | 1 = data-address comparator, 0 = instruction-address comparator |
| cfg_wr | input | N | Reprogram pulse; clears that comparator's sticky bit |
| cfg_lo | input | N*AW | Low bound, or the compare value for a single comparator |
| cfg_hi | input | N*AW | High bound for a range comparator |
| cfg_mask | input | N*AW | Don't-care bits for a single comparator |
| ia_valid | input | 1 | A retired instruction address is present |
| ia_addr | input | AW | Retired instruction address |
| ia_is_data | input | 1 | The retired instruction is a load/store |
| ia_tag | input | TW | Transfer tag of the retired load/store |
| da_valid | input | 1 | A data-transfer address is present |
| da_addr | input | AW | Data-transfer address |
| dc_valid | input | 1 | A load/store has finished all of its transfers |
| dc_tag | input | TW | Tag of the finished load/store |
| hit_event | output | N | Match for the event consumer |
| hit_tenable | output | N | Match for the trace-enable consumer |
| hit_startstop | output | N | Match for the start/stop consumer |
| hit_view | output | N | Match for the data-view consumer |

## Verification
The assertions check several properties on every cycle. A data-address comparator never holds a sticky bit. A sticky bit only rises after a load/store beat and survives any cycle with no completion. Trace-enable and start/stop always agree. A set sticky bit always shows on the data-view output one cycle later. A single comparator's event output never differs from its raw match. Disabling the unit clears every sticky bit. Two behaviours depend on particular sequences and can only be shown by the bench scenarios: tag-selective clearing, and the overlap of a completion with a fresh match. The bench also sweeps every address of a small configuration to confirm the inclusive range bounds and the masked equality.

// File: rtl/trc_cmp_pkg.sv
package trc_cmp_pkg;

  typedef struct packed {
    logic ev;
    logic te;
    logic ss;
    logic vw;
  } hits_t;

  // Consumer routing: event sees sticky only for range kind,
  // view always, enable and start/stop never.
  function automatic hits_t route_hits(input logic raw, input logic stk,
                                       input logic is_range);
    hits_t r;
    r.ev = raw | (is_range & stk);
    r.te = raw;
    r.ss = raw;
    r.vw = raw | stk;
    return r;
  endfunction

endpackage

// File: rtl/trc_addr_match.sv
module trc_addr_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] mask,
  input  logic          is_range,
  output logic          hit
);
  logic in_range;
  logic eq_masked;

  always_comb begin
    in_range  = (addr >= lo) && (addr <= hi);
    eq_masked = (((addr ^ lo) & ~mask) == '0);
    hit       = is_range ? in_range : eq_masked;
  end
endmodule

// File: rtl/trc_sticky.sv
module trc_sticky #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set,
  input  logic [TW-1:0] set_tag,
  input  logic          done_valid,
  input  logic [TW-1:0] done_tag,
  output logic          sticky
);
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= 1'b0;
      tag_q  <= '0;
    end else if (clr) begin
      sticky <= 1'b0;
    end else if (set) begin
      sticky <= 1'b1;
      tag_q  <= set_tag;
    end else if (done_valid && (done_tag == tag_q)) begin
      sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/trc_cmp_slice.sv
module trc_cmp_slice
  import trc_cmp_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_en,
  input  logic          en,
  input  logic          is_range,
  input  logic          is_data,
  input  logic          wr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] mask,
  input  logic          ia_valid,
  input  logic [AW-1:0] ia_addr,
  input  logic          ia_is_data,
  input  logic [TW-1:0] ia_tag,
  input  logic          da_valid,
  input  logic [AW-1:0] da_addr,
  input  logic          dc_valid,
  input  logic [TW-1:0] dc_tag,
  output logic          ev,
  output logic          te,
  output logic          ss,
  output logic          vw,
  output logic          sticky
);
  logic [AW-1:0] sel_addr;
  logic          sel_valid;
  logic          addr_hit;
  logic          live;
  logic          raw;
  logic          set_stk;
  logic          clr_stk;
  hits_t         hits;

  assign sel_addr  = is_data ? da_addr  : ia_addr;
  assign sel_valid = is_data ? da_valid : ia_valid;
  assign live      = unit_en & en;

  trc_addr_match #(.AW(AW)) u_match (
    .addr     (sel_addr),
    .lo       (lo),
    .hi       (hi),
    .mask     (mask),
    .is_range (is_range),
    .hit      (addr_hit)
  );

  assign raw     = live & sel_valid & addr_hit;
  assign set_stk = raw & ~is_data & ia_is_data;
  assign clr_stk = wr | ~live;

  trc_sticky #(.TW(TW)) u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_stk),
    .set        (set_stk),
    .set_tag    (ia_tag),
    .done_valid (dc_valid),
    .done_tag   (dc_tag),
    .sticky     (sticky)
  );

  assign hits = route_hits(raw, sticky & live, is_range);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= 1'b0;
      te <= 1'b0;
      ss <= 1'b0;
      vw <= 1'b0;
    end else begin
      ev <= hits.ev;
      te <= hits.te;
      ss <= hits.ss;
      vw <= hits.vw;
    end
  end
endmodule

// File: rtl/trc_cmp_bank.sv
module trc_cmp_bank #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unit_en,
  input  logic [N-1:0]    cfg_en,
  input  logic [N-1:0]    cfg_range,
  input  logic [N-1:0]    cfg_data,
  input  logic [N-1:0]    cfg_wr,
  input  logic [N*AW-1:0] cfg_lo,
  input  logic [N*AW-1:0] cfg_hi,
  input  logic [N*AW-1:0] cfg_mask,
  input  logic            ia_valid,
  input  logic [AW-1:0]   ia_addr,
  input  logic            ia_is_data,
  input  logic [TW-1:0]   ia_tag,
  input  logic            da_valid,
  input  logic [AW-1:0]   da_addr,
  input  logic            dc_valid,
  input  logic [TW-1:0]   dc_tag,
  output logic [N-1:0]    hit_event,
  output logic [N-1:0]    hit_tenable,
  output logic [N-1:0]    hit_startstop,
  output logic [N-1:0]    hit_view
);
  logic [N-1:0] sticky_q;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    trc_cmp_slice #(.AW(AW), .TW(TW)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .unit_en    (unit_en),
      .en         (cfg_en[i]),
      .is_range   (cfg_range[i]),
      .is_data    (cfg_data[i]),
      .wr         (cfg_wr[i]),
      .lo         (cfg_lo[i*AW +: AW]),
      .hi         (cfg_hi[i*AW +: AW]),
      .mask       (cfg_mask[i*AW +: AW]),
      .ia_valid   (ia_valid),
      .ia_addr    (ia_addr),
      .ia_is_data (ia_is_data),
      .ia_tag     (ia_tag),
      .da_valid   (da_valid),
      .da_addr    (da_addr),
      .dc_valid   (dc_valid),
      .dc_tag     (dc_tag),
      .ev         (hit_event[i]),
      .te         (hit_tenable[i]),
      .ss         (hit_startstop[i]),
      .vw         (hit_view[i]),
      .sticky     (sticky_q[i])
    );
  end
endmodule

// File: rtl/trc_cmp_chk.sv
module trc_cmp_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         unit_en,
  input logic [N-1:0] cfg_en,
  input logic [N-1:0] cfg_range,
  input logic [N-1:0] cfg_data,
  input logic [N-1:0] cfg_wr,
  input logic         ia_valid,
  input logic         ia_is_data,
  input logic         dc_valid,
  input logic [N-1:0] sticky_q,
  input logic [N-1:0] hit_event,
  input logic [N-1:0] hit_tenable,
  input logic [N-1:0] hit_startstop,
  input logic [N-1:0] hit_view
);
  // R6: enable and start/stop consumers always agree
  p_te_eq_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_tenable == hit_startstop);

  // R10: global disable empties every sticky bit
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (sticky_q == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3: data-address comparators never hold a sticky bit
    p_data_no_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_data[i] |-> !sticky_q[i]);

    // R1: a sticky bit only rises after a load/store beat
    p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky_q[i]) |-> $past(ia_valid && ia_is_data && !cfg_data[i]));

    // R2: without a completion, a sticky bit is kept
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && !dc_valid && unit_en && cfg_en[i] && !cfg_wr[i])
      |=> sticky_q[i]);

    // R4: a held sticky bit shows on the view output
    p_view_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[i] && unit_en && cfg_en[i]) |=> hit_view[i]);

    // R5: a single comparator's event equals its raw match
    p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_event[i] != hit_tenable[i]) |-> $past(cfg_range[i]));
  end
endmodule

bind trc_cmp_bank trc_cmp_chk #(.N(N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .unit_en       (unit_en),
  .cfg_en        (cfg_en),
  .cfg_range     (cfg_range),
  .cfg_data      (cfg_data),
  .cfg_wr        (cfg_wr),
  .ia_valid      (ia_valid),
  .ia_is_data    (ia_is_data),
  .dc_valid      (dc_valid),
  .sticky_q      (sticky_q),
  .hit_event     (hit_event),
  .hit_tenable   (hit_tenable),
  .hit_startstop (hit_startstop),
  .hit_view      (hit_view)
);

// File: tb/sim_trc_cmp_bank.sv
module sim_trc_cmp_bank;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int TW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            unit_en;
  logic [N-1:0]    cfg_en, cfg_range, cfg_data, cfg_wr;
  logic [N*AW-1:0] cfg_lo, cfg_hi, cfg_mask;
  logic            ia_valid, ia_is_data, da_valid, dc_valid;
  logic [AW-1:0]   ia_addr, da_addr;
  logic [TW-1:0]   ia_tag, dc_tag;
  logic [N-1:0]    hit_event, hit_tenable, hit_startstop, hit_view;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trc_cmp_bank #(.N(N), .AW(AW), .TW(TW)) u0 (.*);

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ia_valid = 0; ia_is_data = 0; da_valid = 0; dc_valid = 0;
    cfg_wr = '0;
  endtask

  // Model of raw address match, per R7 and R8
  function automatic logic [N-1:0] raw_hits(input logic [AW-1:0] ia,
                                            input logic [AW-1:0] da);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic [AW-1:0] a, lo, hi, m;
      a  = cfg_data[i] ? da : ia;
      lo = cfg_lo[i*AW +: AW];
      hi = cfg_hi[i*AW +: AW];
      m  = cfg_mask[i*AW +: AW];
      if (cfg_range[i]) r[i] = (int'(a) >= int'(lo)) && (int'(a) <= int'(hi));
      else              r[i] = ((a ^ lo) & ~m) == 0;
    end
    return r;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    // comparator 0: single instr 0x40 mask 0x03; 1: range instr 0x30..0x50
    // comparator 2: single data 0x44;           3: range data 0x10..0x1F
    cfg_en = '1; cfg_range = 4'b1010; cfg_data = 4'b1100; cfg_wr = '0;
    cfg_lo   = {8'h10, 8'h44, 8'h30, 8'h40};
    cfg_hi   = {8'h1F, 8'h00, 8'h50, 8'h00};
    cfg_mask = {8'h00, 8'h00, 8'h00, 8'h03};
    unit_en = 1; ia_addr = 0; da_addr = 0; ia_tag = 0; dc_tag = 0;
    idle();
    rst_n = 0;
    repeat (3) cyc();
    chk("R11 reset view", hit_view, 4'b0);
    chk("R11 reset event", hit_event, 4'b0);
    rst_n = 1;
    cyc();
    chk("R11 idle after reset", hit_tenable | hit_startstop, 4'b0);

    // Sweep every address on both buses, no load/store (R7 R8 R3 R6)
    for (int a = 0; a < 256; a++) begin
      logic [N-1:0] e;
      ia_valid = 1; da_valid = 1; ia_addr = AW'(a); da_addr = AW'(a);
      e = raw_hits(AW'(a), AW'(a));
      cyc();
      chk("R7/R8 tenable", hit_tenable, e);
      chk("R6 startstop", hit_startstop, e);
      chk("R5 event raw", hit_event, e);
      chk("R4 view raw", hit_view, e);
    end
    idle(); cyc();
    chk("R1 no sticky from non-data sweep", hit_view, 4'b0);

    // R1/R5/R6/R4: load/store at 0x41 hits comparators 0 and 1
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h41; ia_tag = 2'd1;
    cyc();
    chk("R1 first beat event", hit_event, 4'b0011);
    idle(); cyc();
    chk("R4 view held by sticky", hit_view, 4'b0011);
    chk("R5 single drops, range holds", hit_event, 4'b0010);
    chk("R6 tenable ignores sticky", hit_tenable, 4'b0000);
    chk("R6 startstop ignores sticky", hit_startstop, 4'b0000);
    cyc();
    chk("R4 view still held", hit_view, 4'b0011);

    // R2: wrong tag has no effect
    dc_valid = 1; dc_tag = 2'd2; cyc();
    idle(); cyc();
    chk("R2 wrong tag keeps sticky", hit_view, 4'b0011);
    dc_valid = 1; dc_tag = 2'd1; cyc();
    chk("R2 completion cycle still held", hit_view, 4'b0011);
    idle(); cyc();
    chk("R2 matching tag clears", hit_view, 4'b0000);

    // R3: load/store at 0x44 with data beat 0x44
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h44; ia_tag = 2'd0;
    da_valid = 1; da_addr = 8'h44;
    cyc();
    chk("R3 data comparator raw hit", hit_view, 4'b0110);
    idle(); cyc();
    chk("R3 data comparator not sticky", hit_view, 4'b0010);
    dc_valid = 1; dc_tag = 2'd0; cyc();
    idle(); cyc();
    chk("R2 cleared tag 0", hit_view, 4'b0000);

    // R9: new match and old completion in the same cycle
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h35; ia_tag = 2'd1;
    cyc(); idle(); cyc();
    chk("R9 set tag 1", hit_view, 4'b0010);
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h36; ia_tag = 2'd3;
    dc_valid = 1; dc_tag = 2'd1;
    cyc(); idle(); cyc();
    chk("R9 sticky kept across overlap", hit_view, 4'b0010);
    dc_valid = 1; dc_tag = 2'd1; cyc(); idle(); cyc();
    chk("R9 old tag no longer clears", hit_view, 4'b0010);
    dc_valid = 1; dc_tag = 2'd3; cyc(); idle(); cyc();
    chk("R9 new tag clears", hit_view, 4'b0000);

    // R1: matching non-data instruction sets nothing
    ia_valid = 1; ia_is_data = 0; ia_addr = 8'h35; cyc();
    chk("R1 non-data raw hit", hit_view, 4'b0010);
    idle(); cyc();
    chk("R1 non-data leaves no sticky", hit_view, 4'b0000);

    // R10: reprogram pulse clears
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h35; ia_tag = 2'd2;
    cyc(); idle();
    cfg_wr = 4'b0010; cyc();
    chk("R10 wr cycle still shows sticky", hit_view, 4'b0010);
    idle(); cyc();
    chk("R10 wr cleared sticky", hit_view, 4'b0000);

    // R10: unit disable gates outputs and clears
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h35; ia_tag = 2'd2;
    cyc(); idle();
    unit_en = 0; cyc();
    chk("R10 disabled outputs zero", hit_view, 4'b0000);
    unit_en = 1; cyc();
    chk("R10 disable cleared sticky", hit_view, 4'b0000);

    // R10: comparator enable low gates outputs and clears
    ia_valid = 1; ia_is_data = 1; ia_addr = 8'h35; ia_tag = 2'd2;
    cyc(); idle();
    cfg_en = 4'b1101; cyc();
    chk("R10 cfg_en low gates", hit_view, 4'b0000);
    cfg_en = 4'b1111; cyc();
    chk("R10 cfg_en low cleared sticky", hit_view, 4'b0000);

    report();
  end
endmodule